// File: doc/BRIEF.md
# Bunch-Crossing and Turn Counter Rebuilder

This block rebuilds the accelerator timing state on a board that is fed by a slow serial timing link. The crossing and turn numbers never travel over the link. The block rebuilds them from a marker that goes high in the first period of every turn. It keeps a crossing counter that runs once per clock period and a turn counter that steps once per marker.

Each level-1 accept is forwarded as a one-cycle strobe tagged with the crossing and turn numbers of the cycle it arrived on. A rising edge on the reinitialize line becomes a one-cycle request pulse. After the counters have locked to a first marker, a sticky flag reports any marker that arrives at the wrong place and any marker that fails to arrive.

For bench testing without the timing system, a mode input replaces the link marker with one generated inside the block at every crossing wrap. In that mode the block drops the link's marker, accept and reinitialize lines. The block runs in the timing-clock domain. The choice between the link clock and a local oscillator is made ahead of it.

Top module: `bxturn_rebuild`

## Requirements
- R1: After reset, the crossing number and turn number are 0, the accept strobe, the reinit pulse and the slip flag are 0, and the block is unlocked.
- R2: Without a marker, the crossing number increments by one each clock, stays within 0..BX_LAST (default 159), and goes to 0 on the clock after it reads BX_LAST.
- R3: In link mode, a high `link_turn` sampled on a clock edge makes the crossing number 0 after that edge and adds one to the turn number.
- R4: The turn number is TURN_W bits wide (default 16) and rolls over from all ones to 0 on the next marker.
- R5: Once locked, the slip flag sets on the clock after a cycle in which the marker is high while the crossing number is not BX_LAST, or the marker is low while it is BX_LAST. The flag then stays set until a reinit pulse or reset.
- R6: The block becomes locked on the first marker after reset or after a reinit. While unlocked, no marker position and no missing marker sets the slip flag.
- R7: In link mode, a rising edge on `link_init` gives exactly one cycle of `init_req_o` on the next clock, however long the line stays high. The same edge clears the slip flag and unlocks the block, unless a marker is present in that same cycle, in which case the block relocks at once.
- R8: In link mode, each cycle with `link_accept` high gives `acc_stb_o` high for the following cycle only. The strobe's tags carry the crossing and turn numbers shown in the cycle the accept was sampled.
- R9: When `local_mode` is 1, the block makes its own marker in each cycle where the crossing number is BX_LAST. `link_turn`, `link_accept` and `link_init` have no effect in that mode, so there is no strobe, no reinit pulse and no new slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (link-recovered or local) |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mode | input | 1 | 1 = generate the turn marker internally and ignore the link |
| link_turn | input | 1 | First-period-of-turn marker from the link |
| link_accept | input | 1 | Level-1 accept from the link |
| link_init | input | 1 | Reinitialize request line from the link |
| bx_o | output | BX_W | Current crossing number |
| turn_o | output | TURN_W | Current turn number |
| acc_stb_o | output | 1 | One-cycle accept strobe |
| acc_bx_o | output | BX_W | Crossing number tagged to the accept |
| acc_turn_o | output | TURN_W | Turn number tagged to the accept |
| init_req_o | output | 1 | One-cycle reinitialize request |
| sync_err_o | output | 1 | Sticky slip flag |

## Verification
The in-line properties check the following on every cycle:
- The crossing range and its wrap.
- That a link marker zeroes the crossing number and steps the turn number.
- The accept strobe's timing and tags.
- That the reinit output is a single pulse.
- That the slip flag holds until a reinit.
- That local mode stays silent.

The lock rules can only be shown by the bench's directed scenarios: a first misaligned marker raises no flag, while a missing or early marker afterwards does. The same holds for the turn counter rolling over after 65536 markers, a long-held reinit line, and link activity being ignored in local mode. In all of these, a behavioural model is compared against the outputs on every clock.

// File: rtl/bxturn_rebuild.sv
module bxturn_rebuild #(
  parameter int BX_LAST = 159,
  parameter int TURN_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          local_mode,
  input  logic                          link_turn,
  input  logic                          link_accept,
  input  logic                          link_init,
  output logic [$clog2(BX_LAST+1)-1:0]  bx_o,
  output logic [TURN_W-1:0]             turn_o,
  output logic                          acc_stb_o,
  output logic [$clog2(BX_LAST+1)-1:0]  acc_bx_o,
  output logic [TURN_W-1:0]             acc_turn_o,
  output logic                          init_req_o,
  output logic                          sync_err_o
);
  localparam int BX_W = $clog2(BX_LAST+1);
  localparam logic [BX_W-1:0] BX_END = BX_W'(BX_LAST);

  logic [BX_W-1:0]   bx_q;
  logic [TURN_W-1:0] turn_q;
  logic              locked_q, init_d_q;

  wire at_last   = (bx_q == BX_END);
  wire mark      = local_mode ? at_last : link_turn;
  wire init_rise = !local_mode && link_init && !init_d_q;
  wire acc_fire  = !local_mode && link_accept;
  wire slip      = locked_q && (mark != at_last);

  assign bx_o   = bx_q;
  assign turn_o = turn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bx_q       <= '0;
      turn_q     <= '0;
      locked_q   <= 1'b0;
      init_d_q   <= 1'b0;
      init_req_o <= 1'b0;
      sync_err_o <= 1'b0;
      acc_stb_o  <= 1'b0;
      acc_bx_o   <= '0;
      acc_turn_o <= '0;
    end else begin
      bx_q       <= (mark || at_last) ? '0 : bx_q + 1'b1;
      if (mark) turn_q <= turn_q + 1'b1;
      init_d_q   <= link_init;
      init_req_o <= init_rise;
      if (init_rise) begin
        sync_err_o <= 1'b0;
        locked_q   <= mark;
      end else begin
        if (slip) sync_err_o <= 1'b1;
        if (mark) locked_q   <= 1'b1;
      end
      acc_stb_o <= acc_fire;
      if (acc_fire) begin
        acc_bx_o   <= bx_q;
        acc_turn_o <= turn_q;
      end
    end
  end

  AST_BX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bx_o <= BX_END); // R2
  AST_BX_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (bx_o == BX_END) |=> (bx_o == '0)); // R2
  AST_MARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!local_mode && link_turn) |=> (bx_o == '0)); // R3
  AST_TURN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!local_mode && link_turn) |=> (turn_o == $past(turn_o) + TURN_W'(1))); // R4
  AST_ACC_TAG: assert property (@(posedge clk) disable iff (!rst_n) (!local_mode && link_accept) |=> (acc_stb_o && acc_bx_o == $past(bx_o) && acc_turn_o == $past(turn_o))); // R8
  AST_ACC_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !(!local_mode && link_accept) |=> !acc_stb_o); // R8
  AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n) init_req_o |=> !init_req_o); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sync_err_o |=> (sync_err_o || init_req_o)); // R5
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) local_mode |=> (!acc_stb_o && !init_req_o)); // R9
  AST_LOCAL_NOSLIP: assert property (@(posedge clk) disable iff (!rst_n) (local_mode && !sync_err_o) |=> !sync_err_o); // R9
endmodule

// File: tb/bxturn_rebuild_tb.sv
module bxturn_rebuild_tb;
  localparam int LAST = 159;
  logic clk = 0, rst_n = 0;
  logic local_mode = 0, link_turn = 0, link_accept = 0, link_init = 0;
  logic [7:0]  bx_o, acc_bx_o;
  logic [15:0] turn_o, acc_turn_o;
  logic acc_stb_o, init_req_o, sync_err_o;

  bxturn_rebuild u_dut (
    .clk(clk), .rst_n(rst_n), .local_mode(local_mode), .link_turn(link_turn),
    .link_accept(link_accept), .link_init(link_init), .bx_o(bx_o), .turn_o(turn_o),
    .acc_stb_o(acc_stb_o), .acc_bx_o(acc_bx_o), .acc_turn_o(acc_turn_o),
    .init_req_o(init_req_o), .sync_err_o(sync_err_o));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  int m_bx = 0, m_turn = 0, m_locked = 0, m_err = 0, m_initd = 0;
  int m_stb = 0, m_abx = 0, m_aturn = 0, m_ireq = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog expired (got %0d cycles, expected < 190000)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string r, input int got, input int exp, input string what);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check(tag, bx_o, m_bx, "bx");
    check(tag, turn_o, m_turn, "turn");
    check(tag, sync_err_o, m_err, "sync_err");
    check(tag, init_req_o, m_ireq, "init_req");
    check(tag, acc_stb_o, m_stb, "acc_stb");
    if (m_stb != 0) begin
      check(tag, acc_bx_o, m_abx, "acc_bx");
      check(tag, acc_turn_o, m_aturn, "acc_turn");
    end
  endtask

  task automatic step(input bit t, input bit a, input bit i, input bit l);
    int mark, rise, at_last;
    link_turn = t; link_accept = a; link_init = i; local_mode = l;
    at_last = (m_bx == LAST);
    mark = l ? at_last : int'(t);
    rise = (!l && i && !m_initd) ? 1 : 0;
    if (rise != 0) begin
      m_err = 0; m_locked = mark;
    end else begin
      if (m_locked != 0 && mark != at_last) m_err = 1;
      if (mark != 0) m_locked = 1;
    end
    m_ireq = rise;
    m_initd = i;
    m_stb = (!l && a) ? 1 : 0;
    if (m_stb != 0) begin m_abx = m_bx; m_aturn = m_turn; end
    m_bx = (mark != 0 || at_last != 0) ? 0 : m_bx + 1;
    if (mark != 0) m_turn = (m_turn + 1) % 65536;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic aligned(input int n, input bit acc_rand);
    for (int k = 0; k < n; k++)
      step(m_bx == LAST, acc_rand ? ($urandom % 7 == 0) : 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all();                               // R1 reset state
    tag = "R2"; for (int k = 0; k < 400; k++) step(0, 0, 0, 0);
    tag = "R6"; step(1, 0, 0, 0);                // first marker off-position, no slip
    check("R6", sync_err_o, 0, "no slip on lock");
    tag = "R3"; aligned(500, 0);
    tag = "R8"; aligned(600, 1);
    step(m_bx == LAST, 1, 0, 0); step(0, 1, 0, 0); step(0, 1, 0, 0);
    tag = "R5"; while (m_bx != LAST) step(0, 0, 0, 0);
    step(0, 0, 0, 0);                            // missing marker
    check("R5", sync_err_o, 1, "slip on missing marker");
    for (int k = 0; k < 300; k++) step(0, 0, 0, 0);
    check("R5", sync_err_o, 1, "slip sticky");
    tag = "R7"; for (int k = 0; k < 5; k++) step(0, 0, 1, 0);
    check("R7", sync_err_o, 0, "slip cleared");
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);                            // relock off-position
    check("R7", sync_err_o, 0, "unlocked after init");
    step(0, 0, 0, 0); step(1, 0, 0, 0);          // early marker while locked
    check("R5", sync_err_o, 1, "slip on early marker");
    tag = "R4"; step(0, 0, 1, 0);
    for (int k = 0; k < 65540; k++) step(1, (k % 997) == 0, 0, 0);
    check("R4", turn_o, m_turn, "turn after rollover");
    step(0, 0, 0, 0); step(0, 0, 1, 0);
    tag = "R9";
    for (int k = 0; k < 700; k++) step($urandom % 3 == 0, $urandom % 2 == 0, $urandom % 2 == 0, 1'b1);
    check("R9", sync_err_o, 0, "no slip in local mode");
    tag = "R3"; step(0, 0, 0, 0); aligned(400, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule